// File: doc/BRIEF.md
# Coincident-Event Performance Counter

This block watches one stage of a directory pipeline and counts the cycles in which a chosen combination of conditions occurs together. Fourteen single-cycle event strobes come in every clock. A mask register selects which of them take part. The count register advances by one in each cycle where every selected strobe is high. A single strobe gives a plain event count. Several strobes give a count of their joint occurrence, for example a directory miss on a shared-line request.

Both registers are reached through a small register bus. The bus carries a request strobe, a write flag, an address, write data, and two qualifiers: one marks the request as secure and one marks it as privileged. Read data and an error flag come back one cycle after the request. A request that lacks either qualifier is refused.

Top module: `coincidence_counter`

## Requirements
- R1: Mask bit n selects event input n. The event bits are: 0 valid lookup, 1 cancelled lookup, 2 non-cancelled lookup, 3 locked exclusive-clean request given exclusive-okay, 4 the same request given plain okay, 5 evicted entry inserted, 6 shared-line request, 7 unique-line request, 8 copyback, 9 request causing eviction, 10 directory miss, 11 directory hit that may need snoops, 12 directory evict request, 13 cache maintenance request. With only bit n set, the count rises by one for each cycle in which event n is high, and events outside the mask have no effect.
- R2: When several mask bits are set, the count rises only in a cycle where all selected events are high together. A cycle with only some of them high leaves the count unchanged.
- R3: After reset the mask reads zero and the count reads zero. While the mask is zero, no event pattern changes the count.
- R4: The mask register reads as 64 bits. Bits 13:0 are read-write. Bits 63:14 read as zero and ignore written values.
- R5: Only requests with both the secure and the privileged qualifier high are accepted. A refused request changes no register and returns read data of zero. It also raises the error output for exactly the one cycle after the request.
- R6: The count register is 64 bits and read-write. It resets to zero, and an increment from the all-ones value wraps it to zero.
- R7: A write to the count register in the same cycle as a qualifying event stores the written value, and the increment for that cycle is dropped.
- R8: The mask sits at offset 0x00 and the count at offset 0x08. A read of any other offset returns zero, and a write to any other offset changes nothing. Read data is valid in the cycle after the request and is zero in cycles that follow no accepted read.
- R9: Events are sampled in the cycle they arrive, with no delay. A qualifying event in cycle N is already included in a count read requested in cycle N+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_in | input | 14 | Event strobes for the current pipeline cycle |
| bus_valid | input | 1 | Register request strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 64 | Write data |
| bus_secure | input | 1 | Request is secure |
| bus_priv | input | 1 | Request is privileged |
| bus_rdata | output | 64 | Read data, one cycle after the request |
| bus_err | output | 1 | Refused request, one cycle after the request |

## Verification
The bench drives partial combinations of the selected events. A design that ORs the mask instead of ANDing it would count those cycles too high. With the mask at zero, all strobes are driven high: a design that treats an empty mask as vacuously satisfied would count every cycle. A count preloaded just below all-ones is stepped past the top to check the wrap to zero. A count write is made in the same cycle as a qualifying event; a design with the wrong priority would show the written value plus one. Requests missing one of the two qualifiers must leave the mask untouched and must return zero data with a single-cycle error. A design that checked only one qualifier, or stretched the error, would fail here.

// File: rtl/coincidence_counter.sv
module coincidence_counter #(
  parameter int EVENTS   = 14,
  parameter int DATA_W   = 64,
  parameter int ADDR_W   = 8,
  parameter int MASK_OFS = 0,
  parameter int CNT_OFS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EVENTS-1:0] ev_in,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_secure,
  input  logic              bus_priv,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err
);
  localparam int PAD_W = DATA_W - EVENTS;

  logic [EVENTS-1:0] mask_q;
  logic [DATA_W-1:0] cnt_q;

  wire granted  = bus_valid & bus_secure & bus_priv;
  wire sel_mask = bus_addr == ADDR_W'(MASK_OFS);
  wire sel_cnt  = bus_addr == ADDR_W'(CNT_OFS);
  wire mask_wr  = granted & bus_write & sel_mask;
  wire cnt_wr   = granted & bus_write & sel_cnt;
  wire rd       = granted & ~bus_write;
  wire hit      = (|mask_q) & ((ev_in & mask_q) == mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q    <= '0;
      cnt_q     <= '0;
      bus_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= bus_wdata[EVENTS-1:0];
      if (cnt_wr)   cnt_q <= bus_wdata;
      else if (hit) cnt_q <= cnt_q + 1'b1;
      bus_err <= bus_valid & ~(bus_secure & bus_priv);
      if (rd && sel_mask)     bus_rdata <= {{PAD_W{1'b0}}, mask_q};
      else if (rd && sel_cnt) bus_rdata <= cnt_q;
      else                    bus_rdata <= '0;
    end
  end

  // R3
  idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mask_q) == '0 && !$past(cnt_wr)) |-> cnt_q == $past(cnt_q));

  // R5
  refused_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !(bus_secure && bus_priv)) |=> (bus_err && bus_rdata == '0));

  // R5
  refused_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !(bus_secure && bus_priv)) |=> $stable(mask_q));

  // R4
  mask_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel_mask) |=> bus_rdata[DATA_W-1:EVENTS] == '0);

  // R6
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !cnt_wr && cnt_q == '1) |=> cnt_q == '0);

  // R7
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> cnt_q == $past(bus_wdata));
endmodule

// File: tb/coincidence_counter_test.sv
`timescale 1ns/1ps
module coincidence_counter_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [13:0] ev_in = '0;
  logic        bus_valid = 0, bus_write = 0, bus_secure = 0, bus_priv = 0;
  logic [7:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        bus_err;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  coincidence_counter uut (.clk(clk), .rst_n(rst_n), .ev_in(ev_in), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_secure(bus_secure),
    .bus_priv(bus_priv), .bus_rdata(bus_rdata), .bus_err(bus_err));

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [63:0] d, logic sec = 1, logic prv = 1);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_secure = sec; bus_priv = prv;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [63:0] d, output logic e,
                    input logic sec = 1, input logic prv = 1);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a; bus_secure = sec; bus_priv = prv;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata; e = bus_err;
  endtask

  task automatic pulse(logic [13:0] p, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ev_in = p;
    end
    @(negedge clk); ev_in = '0;
  endtask

  task automatic t_reset();
    logic [63:0] d; logic e;
    rd(8'h00, d, e); chk("R3 mask after reset", d, 0);
    rd(8'h08, d, e); chk("R3 count after reset", d, 0);
    pulse(14'h3FFF, 5);
    rd(8'h08, d, e); chk("R3 zero mask counts nothing", d, 0);
  endtask

  task automatic t_single();
    logic [63:0] d; logic e;
    wr(8'h00, 64'h40);
    pulse(14'h0040, 3);
    pulse(14'h3FBF, 2);
    rd(8'h08, d, e); chk("R1 single event count", d, 3);
    wr(8'h08, 0);
  endtask

  task automatic t_and();
    logic [63:0] d; logic e;
    wr(8'h00, 64'h440);
    pulse(14'h0040, 2);
    pulse(14'h0400, 2);
    pulse(14'h0440, 1);
    pulse(14'h3FFF, 1);
    rd(8'h08, d, e); chk("R2 coincidence only", d, 2);
    rd(8'h00, d, e); chk("R1 mask readback", d, 64'h440);
    wr(8'h08, 0);
  endtask

  task automatic t_reserved();
    logic [63:0] d; logic e;
    wr(8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8'h00, d, e); chk("R4 reserved bits read zero", d, 64'h3FFF);
  endtask

  task automatic t_access();
    logic [63:0] d; logic e;
    wr(8'h00, 64'h1);
    wr(8'h00, 64'h2, 0, 1);
    wr(8'h00, 64'h4, 1, 0);
    rd(8'h00, d, e); chk("R5 refused writes keep mask", d, 1);
    rd(8'h00, d, e, 0, 1); chk("R5 refused read data", d, 0); chk("R5 error raised", e, 1);
    @(negedge clk); chk("R5 error lasts one cycle", bus_err, 0);
    rd(8'h08, d, e, 1, 0); chk("R5 unprivileged read data", d, 0); chk("R5 error raised", e, 1);
    rd(8'h00, d, e); chk("R5 granted read no error", e, 0);
  endtask

  task automatic t_wrap();
    logic [63:0] d; logic e;
    wr(8'h08, 64'hFFFF_FFFF_FFFF_FFFE);
    rd(8'h08, d, e); chk("R6 count writable", d, 64'hFFFF_FFFF_FFFF_FFFE);
    pulse(14'h0001, 2);
    rd(8'h08, d, e); chk("R6 wrap to zero", d, 0);
  endtask

  task automatic t_priority();
    logic [63:0] d; logic e;
    wr(8'h08, 5);
    @(negedge clk);
    ev_in = 14'h0001; bus_valid = 1; bus_write = 1; bus_addr = 8'h08; bus_wdata = 100;
    bus_secure = 1; bus_priv = 1;
    @(negedge clk);
    ev_in = '0; bus_valid = 0; bus_write = 0;
    rd(8'h08, d, e); chk("R7 write beats increment", d, 100);
  endtask

  task automatic t_addr();
    logic [63:0] d; logic e;
    rd(8'h10, d, e); chk("R8 unmapped read", d, 0);
    wr(8'h10, 64'h2);
    wr(8'h18, 64'h7);
    rd(8'h00, d, e); chk("R8 unmapped write keeps mask", d, 1);
    rd(8'h08, d, e); chk("R8 unmapped write keeps count", d, 100);
    @(negedge clk); chk("R8 rdata idle zero", bus_rdata, 0);
  endtask

  task automatic t_timing();
    logic [63:0] d; logic e;
    wr(8'h08, 0);
    @(negedge clk); ev_in = 14'h0001;
    bus_valid = 1; bus_write = 0; bus_addr = 8'h08; bus_secure = 1; bus_priv = 1;
    @(negedge clk); ev_in = '0; bus_valid = 0;
    chk("R9 read in event cycle sees old count", bus_rdata, 0);
    @(negedge clk); ev_in = 14'h0001;
    @(negedge clk); ev_in = '0;
    bus_valid = 1; bus_addr = 8'h08;
    @(negedge clk); bus_valid = 0;
    chk("R9 event visible next cycle", bus_rdata, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_single();
    t_and();
    t_reserved();
    t_access();
    t_wrap();
    t_priority();
    t_addr();
    t_timing();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule